// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an addressing-mode request into the address a load/store datapath should use for its operand. Each request carries a mode code, two register indices, a short offset field from the instruction, an operand size and the current program counter. The block holds a small register file. It reads the base and index registers from it. For the auto-modify modes it writes the stepped base register back into the same file.

All modes but one finish in a single cycle. The memory-indirect mode issues one read to memory at an absolute location, holds the request until memory answers with ready, and then returns the word it read as the address. Immediate mode returns the sign-extended offset itself as the result. A second write port lets the surrounding datapath load the register file.

The controller is a two-state machine. `ST_IDLE` accepts a request whenever `start` is high. An accepted memory-indirect request takes the transition idle-to-wait into `ST_MEMWAIT`. Any other accepted request stays in `ST_IDLE` and raises `done` on the next cycle. `ST_MEMWAIT` takes the transition wait-to-idle on the first cycle `mem_rdy` is high. While it waits, it ignores `start`.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done` and `mem_rd` are 0, `ea` is 0 and every register in the file reads as 0.
- R2: Mode 0 (immediate) returns the 12-bit offset sign-extended to 32 bits, with offset bit 11 as the sign.
- R3: Mode 1 returns the contents of register `ra_idx`. Mode 8 (absolute) returns the offset zero-extended.
- R4: Mode 2 returns reg[`ra_idx`] plus the sign-extended offset. Mode 5 returns `pc` plus the sign-extended offset. Both sums wrap modulo 2^32.
- R5: Mode 3 returns reg[`ra_idx`] + reg[`rb_idx`]. Mode 4 returns reg[`ra_idx`] + reg[`rb_idx`] + the sign-extended offset.
- R6: Mode 6 (post-increment) returns the old reg[`ra_idx`] and then adds the step to that register. The step is 1 for size code 0, 2 for size code 1, and 4 for size codes 2 and 3.
- R7: Mode 7 (pre-decrement) subtracts the step from reg[`ra_idx`] and returns the new value. The result wraps below zero.
- R8: A request in any mode other than 9, accepted at a clock edge, raises `done` with `ea` valid in the cycle that follows. `done` lasts one cycle per request. Any register write-back lands on that same edge, so a request issued in the very next cycle already sees the updated register.
- R9: Mode 9 (memory-indirect) raises `mem_rd` in the cycle after acceptance, with `mem_addr` set to the zero-extended offset. `mem_rd` and `mem_addr` stay unchanged until `mem_rdy` is high at a clock edge. In the following cycle `done` is 1, `ea` equals `mem_rdata` and `mem_rd` is 0.
- R10: A `start` that arrives while a memory read is pending has no effect. It produces no extra `done` and no register write-back.
- R11: The external port writes `rf_wdata` into register `rf_widx` on an edge where `rf_we` is 1. If a write-back targets the same register on that same edge, the write-back wins.
- R12: Mode codes 10 to 15 complete in one cycle with `ea` = 0 and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken in the idle state |
| mode | input | 4 | Addressing mode code |
| ra_idx | input | 3 | Base register index |
| rb_idx | input | 3 | Index register index |
| ofs | input | 12 | Instruction offset field |
| size | input | 2 | Operand size code |
| pc | input | 32 | Current program counter |
| rf_we | input | 1 | External register write enable |
| rf_widx | input | 3 | External register write index |
| rf_wdata | input | 32 | External register write data |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rdy | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| ea | output | 32 | Effective address or immediate value |
| done | output | 1 | Result valid, one cycle per request |

## Verification
A controller stuck in `ST_MEMWAIT` shows up within one cycle. Every later one-cycle request then fails to raise `done`. If the controller leaves the wait too early, `mem_rd` drops while `mem_rdy` is still low, or `done` carries a stale `ea`. A wrong write-back is only visible when the register is next read. For that reason each auto-modify case is followed at once by a register-indirect read of the same register. Each priority collision is checked the same way.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        M_IMM     = 4'd0,
        M_REG     = 4'd1,
        M_IDX     = 4'd2,
        M_BASEIDX = 4'd3,
        M_BIO     = 4'd4,
        M_PCREL   = 4'd5,
        M_POSTINC = 4'd6,
        M_PREDEC  = 4'd7,
        M_ABS     = 4'd8,
        M_MEMIND  = 4'd9
    } ea_mode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_MEMWAIT = 1'b1
    } ea_state_e;

    function automatic logic [2:0] size_step(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
    parameter int NREGS = 8,
    parameter int DW    = 32,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_a_idx,
    input  logic [IW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [DW-1:0] wb_data,
    input  logic          ext_en,
    input  logic [IW-1:0] ext_idx,
    input  logic [DW-1:0] ext_data
);

    logic [DW-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wb_en && wb_idx == IW'(g)) begin
                q <= wb_data;
            end else if (ext_en && ext_idx == IW'(g)) begin
                q <= ext_data;
            end
        end
        assign regs[g] = q;
    end

    assign rd_a = regs[rd_a_idx];
    assign rd_b = regs[rd_b_idx];

    // R11
    wb_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> regs[$past(wb_idx)] == $past(wb_data));

    // R11
    ext_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en && !(wb_en && wb_idx == ext_idx)) |=> regs[$past(ext_idx)] == $past(ext_data));

endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 12
) (
    input  logic [3:0]    mode,
    input  logic [1:0]    size,
    input  logic [OW-1:0] ofs,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] ra_val,
    input  logic [AW-1:0] rb_val,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] loc,
    output logic          is_mem,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);

    logic [AW-1:0] ofs_sx;
    logic [AW-1:0] step;
    logic [AW-1:0] dec_val;

    assign ofs_sx  = {{(AW-OW){ofs[OW-1]}}, ofs};
    assign loc     = {{(AW-OW){1'b0}}, ofs};
    assign step    = AW'(size_step(size));
    assign dec_val = ra_val - step;

    always_comb begin
        ea     = '0;
        is_mem = 1'b0;
        wb_en  = 1'b0;
        wb_val = ra_val;
        case (mode)
            M_IMM:     ea = ofs_sx;
            M_REG:     ea = ra_val;
            M_IDX:     ea = ra_val + ofs_sx;
            M_BASEIDX: ea = ra_val + rb_val;
            M_BIO:     ea = ra_val + rb_val + ofs_sx;
            M_PCREL:   ea = pc + ofs_sx;
            M_POSTINC: begin
                ea     = ra_val;
                wb_en  = 1'b1;
                wb_val = ra_val + step;
            end
            M_PREDEC: begin
                ea     = dec_val;
                wb_en  = 1'b1;
                wb_val = dec_val;
            end
            M_ABS:     ea = loc;
            M_MEMIND:  is_mem = 1'b1;
            default:   ea = '0;
        endcase
    end

endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_mem,
    input  logic [AW-1:0] calc_ea,
    input  logic [AW-1:0] loc,
    input  logic          mem_rdy,
    input  logic [AW-1:0] mem_rdata,
    output logic          take,
    output logic [AW-1:0] ea,
    output logic          done,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr
);

    ea_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start && is_mem) state_d = ST_MEMWAIT;
            ST_MEMWAIT: if (mem_rdy)         state_d = ST_IDLE;
        endcase
    end

    assign take = start && (state_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea       <= '0;
            done     <= 1'b0;
            mem_rd   <= 1'b0;
            mem_addr <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (is_mem) begin
                            mem_rd   <= 1'b1;
                            mem_addr <= loc;
                        end else begin
                            ea   <= calc_ea;
                            done <= 1'b1;
                        end
                    end
                end
                ST_MEMWAIT: begin
                    if (mem_rdy) begin
                        ea     <= mem_rdata;
                        done   <= 1'b1;
                        mem_rd <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));

    // R9
    rdy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_rdy) |=> (done && !mem_rd));

    // R10
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEMWAIT && !mem_rdy) |=> !done);

endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OW    = 12,
    parameter int NREGS = 8,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [IW-1:0] ra_idx,
    input  logic [IW-1:0] rb_idx,
    input  logic [OW-1:0] ofs,
    input  logic [1:0]    size,
    input  logic [AW-1:0] pc,
    input  logic          rf_we,
    input  logic [IW-1:0] rf_widx,
    input  logic [AW-1:0] rf_wdata,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rdy,
    input  logic [AW-1:0] mem_rdata,
    output logic [AW-1:0] ea,
    output logic          done
);

    logic [AW-1:0] ra_val, rb_val;
    logic [AW-1:0] calc_ea, loc, wb_val;
    logic          is_mem, calc_wb, take;

    ea_regfile #(.NREGS(NREGS), .DW(AW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (ra_idx),
        .rd_b_idx (rb_idx),
        .rd_a     (ra_val),
        .rd_b     (rb_val),
        .wb_en    (take && calc_wb),
        .wb_idx   (ra_idx),
        .wb_data  (wb_val),
        .ext_en   (rf_we),
        .ext_idx  (rf_widx),
        .ext_data (rf_wdata)
    );

    ea_calc #(.AW(AW), .OW(OW)) u_calc (
        .mode   (mode),
        .size   (size),
        .ofs    (ofs),
        .pc     (pc),
        .ra_val (ra_val),
        .rb_val (rb_val),
        .ea     (calc_ea),
        .loc    (loc),
        .is_mem (is_mem),
        .wb_en  (calc_wb),
        .wb_val (wb_val)
    );

    ea_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_mem    (is_mem),
        .calc_ea   (calc_ea),
        .loc       (loc),
        .mem_rdy   (mem_rdy),
        .mem_rdata (mem_rdata),
        .take      (take),
        .ea        (ea),
        .done      (done),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr)
    );

    // R8
    one_cycle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_mem) |=> done);

    // R9
    mem_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_mem) |=> (mem_rd && !done && mem_addr == $past(loc)));

    // R9
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd);

endmodule

// File: tb/ea_unit_tb.sv
module ea_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  ra_idx = '0, rb_idx = '0;
    logic [11:0] ofs = '0;
    logic [1:0]  size = '0;
    logic [31:0] pc = '0;
    logic        rf_we = 1'b0;
    logic [2:0]  rf_widx = '0;
    logic [31:0] rf_wdata = '0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_rdy = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] ea;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .ra_idx(ra_idx), .rb_idx(rb_idx), .ofs(ofs), .size(size), .pc(pc),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdy(mem_rdy),
        .mem_rdata(mem_rdata), .ea(ea), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ext_write(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        rf_we = 1'b1; rf_widx = idx; rf_wdata = val;
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    // drive one request for one cycle; returns at the negedge after acceptance
    task automatic issue(input logic [3:0] m, input logic [2:0] a, input logic [2:0] b,
                         input logic [11:0] o, input logic [1:0] s, input logic [31:0] p);
        @(negedge clk);
        start = 1'b1; mode = m; ra_idx = a; rb_idx = b; ofs = o; size = s; pc = p;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] idx, output logic [31:0] val);
        issue(4'd1, idx, 3'd0, 12'h0, 2'd0, 32'h0);
        val = ea;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 mem_rd", {31'b0, mem_rd}, 32'd0);
        chk("R1 ea", ea, 32'd0);
        read_reg(3'd5, v);
        chk("R1 reg5", v, 32'd0);
    endtask

    task automatic t_imm;
        issue(4'd0, 3'd0, 3'd0, 12'h9AB, 2'd0, 32'h0);
        chk("R2 neg imm", ea, 32'hFFFFF9AB);
        chk("R2 done", {31'b0, done}, 32'd1);
        issue(4'd0, 3'd0, 3'd0, 12'h123, 2'd0, 32'h0);
        chk("R2 pos imm", ea, 32'h00000123);
    endtask

    task automatic t_reg_abs;
        ext_write(3'd1, 32'h0000_0100);
        issue(4'd1, 3'd1, 3'd0, 12'h0, 2'd0, 32'h0);
        chk("R3 reg ind", ea, 32'h100);
        issue(4'd8, 3'd1, 3'd0, 12'hFFF, 2'd0, 32'h0);
        chk("R3 absolute zext", ea, 32'h0000_0FFF);
    endtask

    task automatic t_index_pcrel;
        issue(4'd2, 3'd1, 3'd0, 12'hFFF, 2'd0, 32'h0);
        chk("R4 index neg", ea, 32'hFF);
        issue(4'd2, 3'd1, 3'd0, 12'h010, 2'd0, 32'h0);
        chk("R4 index pos", ea, 32'h110);
        issue(4'd5, 3'd0, 3'd0, 12'h800, 2'd0, 32'h1000);
        chk("R4 pcrel neg", ea, 32'h800);
        issue(4'd5, 3'd0, 3'd0, 12'h008, 2'd0, 32'hFFFF_FFFC);
        chk("R4 pcrel wrap", ea, 32'h4);
    endtask

    task automatic t_base;
        ext_write(3'd2, 32'h2000);
        ext_write(3'd3, 32'h30);
        issue(4'd3, 3'd2, 3'd3, 12'h0, 2'd0, 32'h0);
        chk("R5 base+idx", ea, 32'h2030);
        issue(4'd4, 3'd2, 3'd3, 12'hFFC, 2'd0, 32'h0);
        chk("R5 base+idx+ofs", ea, 32'h202C);
    endtask

    task automatic t_postinc;
        logic [31:0] v;
        ext_write(3'd4, 32'h500);
        issue(4'd6, 3'd4, 3'd0, 12'h0, 2'd0, 32'h0);
        chk("R6 byte ea", ea, 32'h500);
        issue(4'd6, 3'd4, 3'd0, 12'h0, 2'd1, 32'h0);
        chk("R6 half ea", ea, 32'h501);
        issue(4'd6, 3'd4, 3'd0, 12'h0, 2'd3, 32'h0);
        chk("R6 size3 ea", ea, 32'h503);
        read_reg(3'd4, v);
        chk("R6 reg after", v, 32'h507);
    endtask

    task automatic t_predec;
        logic [31:0] v;
        ext_write(3'd5, 32'h10);
        issue(4'd7, 3'd5, 3'd0, 12'h0, 2'd2, 32'h0);
        chk("R7 word ea", ea, 32'hC);
        issue(4'd7, 3'd5, 3'd0, 12'h0, 2'd1, 32'h0);
        chk("R7 half ea", ea, 32'hA);
        read_reg(3'd5, v);
        chk("R7 reg after", v, 32'hA);
        ext_write(3'd6, 32'h0);
        issue(4'd7, 3'd6, 3'd0, 12'h0, 2'd0, 32'h0);
        chk("R7 wrap", ea, 32'hFFFF_FFFF);
    endtask

    task automatic t_back_to_back;
        logic [31:0] v;
        ext_write(3'd1, 32'h40);
        @(negedge clk);
        start = 1'b1; mode = 4'd6; ra_idx = 3'd1; size = 2'd2;
        @(negedge clk);
        chk("R8 first done", {31'b0, done}, 32'd1);
        chk("R8 first ea", ea, 32'h40);
        @(negedge clk);
        start = 1'b0;
        chk("R8 second done", {31'b0, done}, 32'd1);
        chk("R8 second sees write-back", ea, 32'h44);
        @(negedge clk);
        chk("R8 done drops", {31'b0, done}, 32'd0);
        read_reg(3'd1, v);
        chk("R8 reg after two", v, 32'h48);
    endtask

    task automatic t_memind;
        issue(4'd9, 3'd0, 3'd0, 12'h123, 2'd0, 32'h0);
        chk("R9 mem_rd up", {31'b0, mem_rd}, 32'd1);
        chk("R9 mem_addr", mem_addr, 32'h123);
        chk("R9 no done yet", {31'b0, done}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 held", {31'b0, mem_rd}, 32'd1);
            chk("R9 addr stable", mem_addr, 32'h123);
            chk("R9 waiting", {31'b0, done}, 32'd0);
        end
        mem_rdy = 1'b1; mem_rdata = 32'hCAFE_0000;
        @(negedge clk);
        mem_rdy = 1'b0;
        chk("R9 done", {31'b0, done}, 32'd1);
        chk("R9 ea from mem", ea, 32'hCAFE_0000);
        chk("R9 mem_rd drops", {31'b0, mem_rd}, 32'd0);
        @(negedge clk);
        chk("R9 single done", {31'b0, done}, 32'd0);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        ext_write(3'd2, 32'h80);
        issue(4'd9, 3'd0, 3'd0, 12'h040, 2'd0, 32'h0);
        @(negedge clk);
        start = 1'b1; mode = 4'd6; ra_idx = 3'd2; size = 2'd2;
        @(negedge clk);
        start = 1'b0;
        chk("R10 no done while waiting", {31'b0, done}, 32'd0);
        chk("R10 still reading", {31'b0, mem_rd}, 32'd1);
        mem_rdy = 1'b1; mem_rdata = 32'h1234_5678;
        @(negedge clk);
        mem_rdy = 1'b0;
        chk("R10 ea from mem", ea, 32'h1234_5678);
        @(negedge clk);
        chk("R10 no extra done", {31'b0, done}, 32'd0);
        read_reg(3'd2, v);
        chk("R10 reg untouched", v, 32'h80);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        ext_write(3'd7, 32'h700);
        @(negedge clk);
        start = 1'b1; mode = 4'd6; ra_idx = 3'd7; size = 2'd2;
        rf_we = 1'b1; rf_widx = 3'd7; rf_wdata = 32'hDEAD;
        @(negedge clk);
        start = 1'b0; rf_we = 1'b0;
        read_reg(3'd7, v);
        chk("R11 write-back wins", v, 32'h704);
        @(negedge clk);
        start = 1'b1; mode = 4'd6; ra_idx = 3'd7; size = 2'd0;
        rf_we = 1'b1; rf_widx = 3'd0; rf_wdata = 32'h55;
        @(negedge clk);
        start = 1'b0; rf_we = 1'b0;
        read_reg(3'd0, v);
        chk("R11 other reg written", v, 32'h55);
        read_reg(3'd7, v);
        chk("R11 base stepped", v, 32'h705);
    endtask

    task automatic t_undef;
        logic [31:0] v;
        ext_write(3'd3, 32'h3333);
        for (int m = 10; m < 16; m++) begin
            issue(4'(m), 3'd3, 3'd3, 12'h7FF, 2'd2, 32'h100);
            chk("R12 done", {31'b0, done}, 32'd1);
            chk("R12 ea zero", ea, 32'd0);
        end
        read_reg(3'd3, v);
        chk("R12 reg unchanged", v, 32'h3333);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_imm();
        t_reg_abs();
        t_index_pcrel();
        t_base();
        t_postinc();
        t_predec();
        t_back_to_back();
        t_memind();
        t_busy_ignore();
        t_priority();
        t_undef();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule